// File: doc/BRIEF.md
# Four-level priority interrupt controller

This block sits beside an 8-bit microcontroller core and decides which of fifteen interrupt sources is presented to the CPU. It holds one request flag per hardware event. Peripheral event pulses set these flags. Software can also set and clear them through strobe masks. Each source has its own enable bit, and one global enable bit gates every source. Each source also has two priority bits, which together give one of four levels.

The CPU sees a single request, together with the winning source index and its level. The CPU accepts a request with an acknowledge pulse and signals the end of a handler with a return pulse. The block keeps a small stack of the levels now in service. A request of strictly higher level therefore preempts a running handler, and the preempted handler continues after the higher one returns. A request of equal or lower level waits.

Some flags are cleared automatically when their request is acknowledged. The others are sticky and only software clears them. The converter-done flag rejects software sets. The timer-2 overflow request merges two flags.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all flags, enables and priority bits are 0, `irq_req` is 0 and `svc_depth` is 0.
- R2: A source's level is {high-priority bit, low-priority bit}, where 3 is the highest level. Among eligible sources, the one with the highest level wins, whatever its index.
- R3: Among eligible sources at the same level, the lowest source index wins.
- R4: Enable word bit 15 is the global enable and bits 14..0 enable sources 14..0. A source is eligible only when its flag is pending, its own enable bit is 1 and the global bit is 1.
- R5: `irq_req` is raised only when nothing is in service, or when the winner's level is strictly above the level on top of the service stack. A winner at an equal level waits.
- R6: An acknowledge while `irq_req` is high pushes the winning level. A return pulse pops one level. After a pop, the preempted level is again shown on `svc_lvl`.
- R7: Flags 4..15 (serial 0, serial 1, converter, capture 0..3, compare 0..2, 8-bit and 16-bit overflow) are sticky. An acknowledge does not clear them; only a software clear does.
- R8: Flags 0..3 (external 0, timer 0, external 1, timer 1) are cleared when their request is acknowledged.
- R9: Flag 6 (converter done) ignores a software set, but it obeys a software clear.
- R10: A software set of any other flag raises a request exactly as a hardware event would. A software clear cancels a pending request.
- R11: Source 14 requests while flag 14 (8-bit overflow) or flag 15 (16-bit overflow) is set.
- R12: When a hardware event and a software clear hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_evt | input | 16 | Hardware event pulses, one per flag |
| sw_flag_set | input | 16 | Software set strobes, one per flag |
| sw_flag_clr | input | 16 | Software clear strobes, one per flag |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Word select: 0 enables, 1 priority low bits, 2 priority high bits |
| cfg_wdata | input | 16 | Configuration write data |
| irq_ack | input | 1 | CPU accepts the presented request |
| irq_ret | input | 1 | CPU leaves the current handler |
| irq_req | output | 1 | Request to the CPU |
| irq_vec | output | 4 | Winning source index |
| irq_lvl | output | 2 | Level of the winning source |
| svc_depth | output | 3 | Number of levels in service |
| svc_lvl | output | 2 | Level on top of the service stack (0 when empty) |
| flag_q | output | 16 | Current request flags |

## Verification
Some rules are checked by assertions on every cycle. A hardware event always leaves its flag set. A sticky flag stays set unless software clears it. A software set never raises the converter flag. Every presented request is globally and individually enabled and outranks the level in service. The stack depth moves by exactly one on each push or pop. Other behaviour can only be shown by the bench's scenarios: the choice of winner between levels and between indices, a preempted level resuming after a three-deep nest, and automatic clearing on acknowledge.

// File: rtl/prio_irq_pkg.sv
// Package: shared sizes, source indices and flag behaviour masks for the
// four-level interrupt controller. Assumes 15 sources and 16 flags.
package prio_irq_pkg;
    localparam int NUM_SRC   = 15;
    localparam int NUM_FLAG  = 16;
    localparam int LVL_W     = 2;
    localparam int VEC_W     = 4;
    localparam int SVC_DEPTH = 4;
    localparam int DEPTH_W   = 3;

    localparam int SRC_EXT0  = 0;
    localparam int SRC_TMR0  = 1;
    localparam int SRC_EXT1  = 2;
    localparam int SRC_TMR1  = 3;
    localparam int SRC_SER0  = 4;
    localparam int SRC_SER1  = 5;
    localparam int SRC_CONV  = 6;
    localparam int SRC_T2OVF = 14;

    // flags that software may not set
    localparam logic [NUM_FLAG-1:0] SW_SET_BLOCK = 16'h0040;
    // flags that an acknowledge never clears
    localparam logic [NUM_FLAG-1:0] STICKY_MASK  = 16'hFFF0;

    typedef enum logic [1:0] {
        CFG_ENABLE  = 2'd0,
        CFG_PRIO_LO = 2'd1,
        CFG_PRIO_HI = 2'd2
    } cfg_sel_e;
endpackage

// File: rtl/irq_cfg_regs.sv
// Configuration registers: the enable word (global bit on top) and the two
// priority bit words. Assumes single-cycle write strobes from the CPU bus.
module irq_cfg_regs
    import prio_irq_pkg::*;
#(
    parameter int NS = NUM_SRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [NS:0]   cfg_wdata,
    output logic [NS-1:0] src_en,
    output logic          glb_en,
    output logic [NS-1:0] prio_lo,
    output logic [NS-1:0] prio_hi
);
    // capture configuration words on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_en  <= '0;
            glb_en  <= 1'b0;
            prio_lo <= '0;
            prio_hi <= '0;
        end else if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                CFG_ENABLE: begin
                    src_en <= cfg_wdata[NS-1:0];
                    glb_en <= cfg_wdata[NS];
                end
                CFG_PRIO_LO: prio_lo <= cfg_wdata[NS-1:0];
                CFG_PRIO_HI: prio_hi <= cfg_wdata[NS-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_flag_bank.sv
// Request flag bank: hardware events set flags, software sets and clears
// them, acknowledge clears the non-sticky ones. A hardware set wins over
// every clear in the same cycle. Assumes all inputs are single-cycle strobes.
module irq_flag_bank
    import prio_irq_pkg::*;
#(
    parameter int              NF        = NUM_FLAG,
    parameter logic [NF-1:0]   SET_BLOCK = SW_SET_BLOCK,
    parameter logic [NF-1:0]   STICKY    = STICKY_MASK
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] hw_evt,
    input  logic [NF-1:0] sw_set,
    input  logic [NF-1:0] sw_clr,
    input  logic [NF-1:0] ack_clr,
    output logic [NF-1:0] flag_q
);
    logic [NF-1:0] flag_d;

    // merge the update sources, hardware set applied last so it wins
    always_comb begin
        flag_d = flag_q & ~sw_clr;
        flag_d = flag_d | (sw_set & ~SET_BLOCK);
        flag_d = flag_d & ~(ack_clr & ~STICKY);
        flag_d = flag_d | hw_evt;
    end

    // flag storage
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    for (genvar i = 0; i < NF; i++) begin : g_chk
        AST_HW_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            hw_evt[i] |=> flag_q[i]); // R12
        if (STICKY[i]) begin : g_sticky
            AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_q[i] && !sw_clr[i]) |=> flag_q[i]); // R7
        end
        if (SET_BLOCK[i]) begin : g_blk
            AST_NO_SW_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
                (!flag_q[i] && !hw_evt[i]) |=> !flag_q[i]); // R9
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
// Arbiter: among pending, enabled sources picks the highest level, and on a
// tie the lowest index. Purely combinational; assumes registered inputs.
module irq_arbiter
    import prio_irq_pkg::*;
#(
    parameter int NS = NUM_SRC,
    parameter int LW = LVL_W,
    parameter int VW = VEC_W
) (
    input  logic [NS-1:0] pend,
    input  logic [NS-1:0] src_en,
    input  logic          glb_en,
    input  logic [NS-1:0] prio_lo,
    input  logic [NS-1:0] prio_hi,
    output logic          win_valid,
    output logic [VW-1:0] win_idx,
    output logic [LW-1:0] win_lvl
);
    // scan upward, replacing the winner only on a strictly higher level
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        for (int i = 0; i < NS; i++) begin
            if (glb_en && pend[i] && src_en[i] &&
                (!win_valid || {prio_hi[i], prio_lo[i]} > win_lvl)) begin
                win_valid = 1'b1;
                win_idx   = VW'(i);
                win_lvl   = {prio_hi[i], prio_lo[i]};
            end
        end
    end

    AST_WIN_ELIGIBLE: assert final (!win_valid ||
        (glb_en && pend[win_idx] && src_en[win_idx])); // R4
endmodule

// File: rtl/irq_service_stack.sv
// In-service stack: an acknowledge pushes the granted level, a return pops
// one. Assumes pushed levels strictly increase, so the depth never exceeds DEPTH.
module irq_service_stack
    import prio_irq_pkg::*;
#(
    parameter int DEPTH = SVC_DEPTH,
    parameter int LW    = LVL_W,
    parameter int DW    = DEPTH_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [LW-1:0] push_lvl,
    input  logic          pop,
    output logic [DW-1:0] depth,
    output logic [LW-1:0] top_lvl
);
    logic [LW-1:0] lvl_q [DEPTH];
    logic          do_pop;

    assign do_pop = pop && (depth != '0);

    // read the top entry, level 0 when empty
    always_comb begin
        top_lvl = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (DW'(i + 1) == depth) top_lvl = lvl_q[i];
        end
    end

    // update depth and write the pushed level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth <= '0;
            for (int i = 0; i < DEPTH; i++) lvl_q[i] <= '0;
        end else begin
            if (push) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (DW'(i) == (do_pop ? depth - DW'(1) : depth)) lvl_q[i] <= push_lvl;
                end
            end
            if (push && !do_pop)      depth <= depth + DW'(1);
            else if (do_pop && !push) depth <= depth - DW'(1);
        end
    end

    AST_STACK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (depth < DW'(DEPTH))); // R6
    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (depth == $past(depth) + DW'(1))); // R6
    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && depth != '0) |=> (depth == $past(depth) - DW'(1))); // R6
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top: four-level priority interrupt controller. Combines flags, arbitration
// and the in-service stack, and presents one request to the CPU. Assumes
// acknowledge and return are single-cycle pulses from the core.
module prio_irq_ctrl
    import prio_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAG-1:0]  hw_evt,
    input  logic [NUM_FLAG-1:0]  sw_flag_set,
    input  logic [NUM_FLAG-1:0]  sw_flag_clr,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_sel,
    input  logic [NUM_SRC:0]     cfg_wdata,
    input  logic                 irq_ack,
    input  logic                 irq_ret,
    output logic                 irq_req,
    output logic [VEC_W-1:0]     irq_vec,
    output logic [LVL_W-1:0]     irq_lvl,
    output logic [DEPTH_W-1:0]   svc_depth,
    output logic [LVL_W-1:0]     svc_lvl,
    output logic [NUM_FLAG-1:0]  flag_q
);
    logic [NUM_SRC-1:0]  src_en, prio_lo, prio_hi, pend;
    logic                glb_en, win_valid, grant;
    logic [VEC_W-1:0]    win_idx;
    logic [LVL_W-1:0]    win_lvl;
    logic [NUM_FLAG-1:0] ack_clr;

    irq_cfg_regs #(.NS(NUM_SRC)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .src_en(src_en), .glb_en(glb_en),
        .prio_lo(prio_lo), .prio_hi(prio_hi)
    );

    irq_flag_bank #(.NF(NUM_FLAG)) u_flags (
        .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .sw_set(sw_flag_set),
        .sw_clr(sw_flag_clr), .ack_clr(ack_clr), .flag_q(flag_q)
    );

    // map flags onto source request lines; the last source merges the rest
    for (genvar i = 0; i < NUM_SRC - 1; i++) begin : g_pend
        assign pend[i] = flag_q[i];
    end
    assign pend[NUM_SRC-1] = |flag_q[NUM_FLAG-1:NUM_SRC-1];

    irq_arbiter #(.NS(NUM_SRC)) u_arb (
        .pend(pend), .src_en(src_en), .glb_en(glb_en), .prio_lo(prio_lo),
        .prio_hi(prio_hi), .win_valid(win_valid), .win_idx(win_idx),
        .win_lvl(win_lvl)
    );

    // present a request only if it outranks the level in service
    always_comb begin
        irq_req = win_valid && ((svc_depth == '0) || (win_lvl > svc_lvl));
        irq_vec = irq_req ? win_idx : '0;
        irq_lvl = irq_req ? win_lvl : '0;
    end

    assign grant   = irq_ack && irq_req;
    assign ack_clr = grant ? (NUM_FLAG'(1) << win_idx) : '0;

    irq_service_stack #(.DEPTH(SVC_DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(grant), .push_lvl(win_lvl),
        .pop(irq_ret), .depth(svc_depth), .top_lvl(svc_lvl)
    );

    AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (glb_en && src_en[irq_vec])); // R4
    AST_PREEMPT_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && svc_depth != '0) |-> (irq_lvl > svc_lvl)); // R5
    AST_ACK_PUSHES_LVL: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !irq_ret) |=> (svc_lvl == $past(irq_lvl))); // R6
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] hw_evt = '0, sw_set = '0, sw_clr = '0;
    logic        cfg_we = 0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        irq_ack = 0, irq_ret = 0;
    logic        irq_req;
    logic [3:0]  irq_vec;
    logic [1:0]  irq_lvl, svc_lvl;
    logic [2:0]  svc_depth;
    logic [15:0] flag_q;
    int nvec = 0, nerr = 0;
    bit done = 0;

    always #2 clk = ~clk;

    prio_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .sw_flag_set(sw_set),
        .sw_flag_clr(sw_clr), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .irq_ack(irq_ack), .irq_ret(irq_ret),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
        .svc_depth(svc_depth), .svc_lvl(svc_lvl), .flag_q(flag_q)
    );

    task automatic chk(string req, int act, int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle of stimulus, driven and released on falling edges
    task automatic step(logic [15:0] hw, logic [15:0] st, logic [15:0] cl,
                        logic ack, logic ret);
        @(negedge clk);
        hw_evt = hw; sw_set = st; sw_clr = cl; irq_ack = ack; irq_ret = ret;
        @(negedge clk);
        hw_evt = '0; sw_set = '0; sw_clr = '0; irq_ack = 0; irq_ret = 0;
    endtask

    task automatic cfg(logic [1:0] sel, logic [15:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 req", irq_req, 0);
        chk("R1 flags", flag_q, 0);
        chk("R1 depth", svc_depth, 0);
    endtask

    task automatic t_global();
        do_reset();
        cfg(0, 16'h0006);
        step(16'h0002, 0, 0, 0, 0);
        chk("R4 no global", irq_req, 0);
        cfg(0, 16'h8006);
        chk("R4 global on req", irq_req, 1);
        chk("R4 global on vec", irq_vec, 1);
        cfg(0, 16'h8004);
        chk("R4 source off", irq_req, 0);
    endtask

    task automatic t_level();
        do_reset();
        cfg(0, 16'h8204);
        step(16'h0204, 0, 0, 0, 0);
        chk("R3 lowest index", irq_vec, 2);
        cfg(2, 16'h0200);
        chk("R2 higher level vec", irq_vec, 9);
        chk("R2 higher level lvl", irq_lvl, 2);
        cfg(1, 16'h0004);
        chk("R2 level1 loses", irq_vec, 9);
        cfg(2, 16'h0204);
        chk("R2 level3 vec", irq_vec, 2);
        chk("R2 level3 lvl", irq_lvl, 3);
    endtask

    task automatic t_nest();
        do_reset();
        cfg(0, 16'h8481);               // sources 0, 7, 10
        cfg(1, 16'h0480);               // 7 -> level1, 10 -> level3
        cfg(2, 16'h0400);
        step(16'h0001, 0, 0, 0, 0);
        chk("R5 idle req", irq_req, 1);
        step(0, 0, 0, 1, 0);
        chk("R6 push depth", svc_depth, 1);
        chk("R8 autoclear", flag_q[0], 0);
        step(16'h0080, 0, 0, 0, 0);
        chk("R5 preempt vec", irq_vec, 7);
        step(0, 0, 0, 1, 0);
        chk("R6 depth2", svc_depth, 2);
        chk("R6 lvl1", svc_lvl, 1);
        chk("R7 sticky after ack", flag_q[7], 1);
        chk("R5 equal waits", irq_req, 0);
        step(16'h0400, 0, 0, 0, 0);
        chk("R5 level3 preempts", irq_vec, 10);
        step(0, 0, 0, 1, 0);
        chk("R6 depth3", svc_depth, 3);
        step(0, 0, 16'h0400, 0, 0);
        step(0, 0, 0, 0, 1);
        chk("R6 pop resumes lvl1", svc_lvl, 1);
        chk("R5 still equal", irq_req, 0);
        step(0, 0, 0, 0, 1);
        chk("R6 pop resumes lvl0", svc_lvl, 0);
        chk("R5 pending now outranks", irq_vec, 7);
        step(0, 0, 16'h0080, 0, 0);
        chk("R10 sw clear cancels", irq_req, 0);
        step(0, 0, 0, 0, 1);
        chk("R6 empty", svc_depth, 0);
    endtask

    task automatic t_conv();
        do_reset();
        step(0, 16'h0040, 0, 0, 0);
        chk("R9 sw set ignored", flag_q[6], 0);
        step(16'h0040, 0, 0, 0, 0);
        chk("R9 hw set", flag_q[6], 1);
        step(0, 0, 16'h0040, 0, 0);
        chk("R9 sw clear", flag_q[6], 0);
        step(16'h0040, 0, 16'h0040, 0, 0);
        chk("R12 hw beats clear", flag_q[6], 1);
    endtask

    task automatic t_swset();
        do_reset();
        cfg(0, 16'h8008);
        step(0, 16'h0008, 0, 0, 0);
        chk("R10 sw raise", irq_vec, 3);
        chk("R10 sw raise req", irq_req, 1);
        step(0, 0, 16'h0008, 0, 0);
        chk("R10 sw cancel", irq_req, 0);
    endtask

    task automatic t_ovf();
        do_reset();
        cfg(0, 16'hC000);
        step(0, 16'h8000, 0, 0, 0);
        chk("R11 wide overflow", irq_vec, 14);
        chk("R11 wide overflow req", irq_req, 1);
        step(0, 16'h4000, 16'h8000, 0, 0);
        chk("R11 narrow overflow", irq_req, 1);
        step(0, 0, 0, 1, 0);
        chk("R7 overflow sticky", flag_q[14], 1);
        step(0, 0, 16'hC000, 0, 1);
        chk("R11 both clear", irq_req, 0);
    endtask

    initial begin
        t_reset();
        t_global();
        t_level();
        t_nest();
        t_conv();
        t_swset();
        t_ovf();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            nvec++; nerr++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end
endmodule